// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs the bus cycles of a 16-bit controller's external bus. Every access request names a target area. It can name one of four chip-select regions, the special-function-register (SFR) region, or internal memory. From that area and the current wait programming, the block sets how long the cycle lasts. While the cycle runs it drives the address, byte-high enable, read and write strobes, the address latch strobe and the chip selects. It then returns a one-cycle response.

Each chip-select region has two settings. A wait-enable bit chooses whether the region runs with programmed waits or with no waits at all. A 2-bit wait count sets how many waits are added. Software writes both settings through a small register port. The block enforces the safe order for changing them: a write that breaks the order is dropped and raises a sticky flag. The SFR region ignores all region settings and runs at a fixed length of two or three clocks. An internal access keeps the external pins quiet. It also keeps the last external address on the bus.

Requests use a valid/ready handshake. A request moves when `req_valid` and `req_ready` are both high at a clock edge. `req_ready` stays low for the whole cycle, so the requester holds its request until the block is free. The response has no back-pressure. `rsp_valid` is a single-cycle pulse, and the requester must take it when it appears.

Top module: `ebus_wait_ctrl`

## Requirements
- R1: A chip-select region whose wait-enable bit is 0 is busy for 1 clock plus its programmed waits. Region i uses bits [2i+1:2i] of the wait-count register. Code 00 gives 1 wait, 01 gives 2 waits and 10 gives 3 waits. Busy means `req_ready` is low, so these codes give 2, 3 and 4 busy clocks.
- R2: A chip-select region whose wait-enable bit is 1 is busy for exactly 1 clock, whatever its wait count is and whatever `bus_rdy` does.
- R3: Wait-count code 11 behaves as 3 waits, giving 4 busy clocks. `cfg_illegal` is high while any field holds 11, and low when no field does.
- R4: For a region whose wait-enable bit is 0, `bus_rdy` is sampled at the edge that would end the cycle. While it is low, the cycle grows by one clock at a time.
- R5: An SFR access (area code 4 with the default of four regions) is busy for 2 clocks when `sfr_3clk` is 0 and 3 clocks when it is 1. It asserts no chip select and ignores `bus_rdy`.
- R6: An internal access (area code 5 or higher) is busy for 1 clock. During it, the read strobe, write strobe and all chip selects stay high, ALE stays low and `bus_doe` stays low. `bus_addr` and `bus_bhe_n` keep the values from the last chip-select or SFR access. A read returns data 0.
- R7: After reset, the wait-count register is 00h, all wait-enable bits are 0 and `cfg_order_err` is 0. `req_ready` is 1 and the bus pins are idle: strobes and chip selects high, ALE low.
- R8: A write to the wait-count register leaves a region's field unchanged, and sets `cfg_order_err`, if that region's wait-enable bit is 1 and the new field value differs from the current one. The other fields are written normally.
- R9: A write that would move a wait-enable bit from 0 to 1 while that region's field is not 00 leaves the bit at 0 and sets `cfg_order_err`. Clearing a bit is always accepted.
- R10: `cfg_order_err` stays set until reset.
- R11: After a request is accepted, `req_ready` goes low from the next clock until the cycle ends. In the clock after the last busy clock, `rsp_valid` is high for one clock. For a chip-select or SFR read, `rsp_rdata` holds `bus_din` as sampled at the edge that ended the cycle.
- R12: In a chip-select or SFR cycle, ALE is high only in the first busy clock. On a read, `bus_rd_n` is low for every busy clock. On a write, `bus_wr_n` and `bus_doe` are low and high for every busy clock. Only the addressed region's chip select is low, and it is low for the whole cycle.
- R13: The cycle length is fixed when the request is accepted. Register writes during a cycle do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| xw_we | input | 1 | Write strobe for the wait-count register |
| xw_data | input | 8 | New wait-count register value |
| we_we | input | 1 | Write strobe for the wait-enable bits |
| we_data | input | 4 | New wait-enable bits (1 = no waits) |
| sfr_3clk | input | 1 | SFR cycle length select (0: 2 clocks, 1: 3 clocks) |
| cfg_xreg | output | 8 | Current wait-count register |
| cfg_wen | output | 4 | Current wait-enable bits |
| cfg_order_err | output | 1 | Sticky programming-order violation flag |
| cfg_illegal | output | 1 | A wait-count field holds code 11 |
| req_valid | input | 1 | Access request valid |
| req_ready | output | 1 | Block can accept a request |
| req_area | input | 3 | Target area: 0-3 chip select, 4 SFR, 5-7 internal |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Access address |
| req_bhe_n | input | 1 | Byte-high enable for the access (active low) |
| req_wdata | input | 16 | Write data |
| rsp_valid | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data for the completed access |
| bus_addr | output | 20 | External address lines |
| bus_bhe_n | output | 1 | External byte-high enable |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 4 | Chip selects, active low |
| bus_ale | output | 1 | Address latch enable |
| bus_dout | output | 16 | Data driven onto the bus |
| bus_doe | output | 1 | Data output enable (0 = bus released) |
| bus_din | input | 16 | Data read from the bus |
| bus_rdy | input | 1 | External ready (low stretches a waited cycle) |

## Verification
The assertions assume that register writes are single-clock strobes, with data stable at the sampling edge. They also assume that requests are held until a handshake edge. The block samples request fields only at acceptance and `bus_rdy` only at the edge that closes a cycle. The bench therefore drives every input at the falling edge. It starts a new request only after the previous response pulse has been consumed, and it changes `bus_rdy` only between edges while a cycle is in flight. Register writes during a cycle are made deliberately, to show that the latched length stays fixed.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  localparam int unsigned FIELD_W = 2;
  localparam int unsigned LEN_W   = 3;

  typedef enum logic [FIELD_W-1:0] {
    EXP_ONE   = 2'b00,
    EXP_TWO   = 2'b01,
    EXP_THREE = 2'b10,
    EXP_BAD   = 2'b11
  } exp_code_e;

  // Busy clocks for a waited region: one base clock plus the wait count.
  // The illegal code is clamped to the longest legal length.
  function automatic logic [LEN_W-1:0] code_to_len(input logic [FIELD_W-1:0] c);
    case (exp_code_e'(c))
      EXP_ONE:   code_to_len = LEN_W'(2);
      EXP_TWO:   code_to_len = LEN_W'(3);
      default:   code_to_len = LEN_W'(4);
    endcase
  endfunction
endpackage

// File: rtl/wsc_cfg_regs.sv
module wsc_cfg_regs
  import wsc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int XW = FIELD_W * N_AREA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xw_we,
  input  logic [XW-1:0]     xw_data,
  input  logic              we_we,
  input  logic [N_AREA-1:0] we_data,
  output logic [XW-1:0]     xreg,
  output logic [N_AREA-1:0] wen,
  output logic              order_err,
  output logic              illegal
);
  logic [XW-1:0]     xreg_q, xreg_d;
  logic [N_AREA-1:0] wen_q, wen_d;
  logic [N_AREA-1:0] x_block, w_block, bad;
  logic              err_q;

  for (genvar g = 0; g < N_AREA; g++) begin : g_area
    logic [FIELD_W-1:0] cur, nxt;
    assign cur = xreg_q[FIELD_W*g +: FIELD_W];
    assign nxt = xw_data[FIELD_W*g +: FIELD_W];
    // Changing the wait count of a region that runs without waits is refused.
    assign x_block[g] = xw_we && wen_q[g] && (nxt != cur);
    assign xreg_d[FIELD_W*g +: FIELD_W] = (xw_we && !x_block[g]) ? nxt : cur;
    // Switching to no-wait needs the count back at 00 first.
    assign w_block[g] = we_we && we_data[g] && !wen_q[g] && (cur != EXP_ONE);
    assign wen_d[g]   = (we_we && !w_block[g]) ? we_data[g] : wen_q[g];
    assign bad[g]     = (cur == EXP_BAD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xreg_q <= '0;
      wen_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      xreg_q <= xreg_d;
      wen_q  <= wen_d;
      if (|x_block || |w_block) err_q <= 1'b1;
    end
  end

  assign xreg      = xreg_q;
  assign wen       = wen_q;
  assign order_err = err_q;
  assign illegal   = |bad;
endmodule

// File: rtl/wsc_len_calc.sv
module wsc_len_calc
  import wsc_pkg::*;
#(
  parameter int N_AREA = 4,
  localparam int XW = FIELD_W * N_AREA,
  localparam int AREA_W = $clog2(N_AREA + 2)
) (
  input  logic [AREA_W-1:0] area,
  input  logic [XW-1:0]     xreg,
  input  logic [N_AREA-1:0] wen,
  input  logic              sfr_3clk,
  output logic [LEN_W-1:0]  len,
  output logic              use_rdy,
  output logic              is_int
);
  always_comb begin
    len     = LEN_W'(1);
    use_rdy = 1'b0;
    is_int  = 1'b1;
    if (area == AREA_W'(N_AREA)) begin
      is_int = 1'b0;
      len    = sfr_3clk ? LEN_W'(3) : LEN_W'(2);
    end
    for (int i = 0; i < N_AREA; i++) begin
      if (area == AREA_W'(i)) begin
        is_int = 1'b0;
        if (!wen[i]) begin
          len     = code_to_len(xreg[FIELD_W*i +: FIELD_W]);
          use_rdy = 1'b1;
        end else begin
          len = LEN_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wsc_seq.sv
module wsc_seq
  import wsc_pkg::*;
#(
  parameter int AREA_W = 3,
  parameter int DW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic [DW-1:0]     req_wdata,
  input  logic [LEN_W-1:0]  len,
  input  logic              use_rdy,
  input  logic              is_int,
  input  logic              bus_rdy,
  input  logic [DW-1:0]     bus_din,
  output logic              accept,
  output logic              cyc_active,
  output logic              cyc_first,
  output logic [AREA_W-1:0] cyc_area,
  output logic              cyc_write,
  output logic              cyc_int,
  output logic [DW-1:0]     cyc_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata
);
  logic             act_q, first_q, rdy_q, wr_q, int_q, rsp_q;
  logic [LEN_W-1:0] cnt_q;
  logic [AREA_W-1:0] area_q;
  logic [DW-1:0]    wd_q, rd_q;
  logic             last;

  assign req_ready = !act_q;
  assign accept    = req_valid && !act_q;
  // The cycle closes when the count is spent and ready (if honoured) is high.
  assign last      = act_q && (cnt_q == '0) && (!rdy_q || bus_rdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      first_q <= 1'b0;
      rdy_q   <= 1'b0;
      wr_q    <= 1'b0;
      int_q   <= 1'b0;
      rsp_q   <= 1'b0;
      cnt_q   <= '0;
      area_q  <= '0;
      wd_q    <= '0;
      rd_q    <= '0;
    end else begin
      rsp_q <= 1'b0;
      if (accept) begin
        act_q   <= 1'b1;
        first_q <= 1'b1;
        cnt_q   <= len - LEN_W'(1);
        rdy_q   <= use_rdy;
        wr_q    <= req_write;
        int_q   <= is_int;
        area_q  <= req_area;
        wd_q    <= req_wdata;
      end else if (act_q) begin
        first_q <= 1'b0;
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - LEN_W'(1);
        end else if (last) begin
          act_q <= 1'b0;
          rsp_q <= 1'b1;
          rd_q  <= (!wr_q && !int_q) ? bus_din : '0;
        end
      end
    end
  end

  assign cyc_active = act_q;
  assign cyc_first  = first_q;
  assign cyc_area   = area_q;
  assign cyc_write  = wr_q;
  assign cyc_int    = int_q;
  assign cyc_wdata  = wd_q;
  assign rsp_valid  = rsp_q;
  assign rsp_rdata  = rd_q;
endmodule

// File: rtl/wsc_pins.sv
module wsc_pins #(
  parameter int N_AREA = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int AREA_W = $clog2(N_AREA + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_is_int,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_bhe_n,
  input  logic              cyc_active,
  input  logic              cyc_first,
  input  logic [AREA_W-1:0] cyc_area,
  input  logic              cyc_write,
  input  logic              cyc_int,
  input  logic [DW-1:0]     cyc_wdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [N_AREA-1:0] bus_cs_n,
  output logic              bus_ale,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe
);
  logic [AW-1:0] addr_q;
  logic          bhe_q;
  logic          ext;

  // Address and byte-high enable are only replaced by external-side accesses.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      bhe_q  <= 1'b1;
    end else if (accept && !req_is_int) begin
      addr_q <= req_addr;
      bhe_q  <= req_bhe_n;
    end
  end

  assign ext       = cyc_active && !cyc_int;
  assign bus_addr  = addr_q;
  assign bus_bhe_n = bhe_q;
  assign bus_rd_n  = !(ext && !cyc_write);
  assign bus_wr_n  = !(ext && cyc_write);
  assign bus_ale   = ext && cyc_first;
  assign bus_doe   = ext && cyc_write;
  assign bus_dout  = cyc_wdata;

  for (genvar g = 0; g < N_AREA; g++) begin : g_cs
    assign bus_cs_n[g] = !(ext && (cyc_area == AREA_W'(g)));
  end
endmodule

// File: rtl/ebus_wait_ctrl.sv
module ebus_wait_ctrl
  import wsc_pkg::*;
#(
  parameter int N_AREA = 4,
  parameter int AW = 20,
  parameter int DW = 16,
  localparam int XW = FIELD_W * N_AREA,
  localparam int AREA_W = $clog2(N_AREA + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xw_we,
  input  logic [XW-1:0]     xw_data,
  input  logic              we_we,
  input  logic [N_AREA-1:0] we_data,
  input  logic              sfr_3clk,
  output logic [XW-1:0]     cfg_xreg,
  output logic [N_AREA-1:0] cfg_wen,
  output logic              cfg_order_err,
  output logic              cfg_illegal,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [AREA_W-1:0] req_area,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic              req_bhe_n,
  input  logic [DW-1:0]     req_wdata,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  output logic [AW-1:0]     bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_rd_n,
  output logic              bus_wr_n,
  output logic [N_AREA-1:0] bus_cs_n,
  output logic              bus_ale,
  output logic [DW-1:0]     bus_dout,
  output logic              bus_doe,
  input  logic [DW-1:0]     bus_din,
  input  logic              bus_rdy
);
  logic [LEN_W-1:0]  len;
  logic              use_rdy, is_int, accept;
  logic              cyc_active, cyc_first, cyc_write, cyc_int;
  logic [AREA_W-1:0] cyc_area;
  logic [DW-1:0]     cyc_wdata;

  wsc_cfg_regs #(.N_AREA(N_AREA)) u_cfg (
    .clk, .rst_n, .xw_we, .xw_data, .we_we, .we_data,
    .xreg(cfg_xreg), .wen(cfg_wen), .order_err(cfg_order_err), .illegal(cfg_illegal)
  );

  wsc_len_calc #(.N_AREA(N_AREA)) u_len (
    .area(req_area), .xreg(cfg_xreg), .wen(cfg_wen), .sfr_3clk,
    .len, .use_rdy, .is_int
  );

  wsc_seq #(.AREA_W(AREA_W), .DW(DW)) u_seq (
    .clk, .rst_n, .req_valid, .req_ready, .req_area, .req_write, .req_wdata,
    .len, .use_rdy, .is_int, .bus_rdy, .bus_din, .accept,
    .cyc_active, .cyc_first, .cyc_area, .cyc_write, .cyc_int, .cyc_wdata,
    .rsp_valid, .rsp_rdata
  );

  wsc_pins #(.N_AREA(N_AREA), .AW(AW), .DW(DW)) u_pins (
    .clk, .rst_n, .accept, .req_is_int(is_int), .req_addr, .req_bhe_n,
    .cyc_active, .cyc_first, .cyc_area, .cyc_write, .cyc_int, .cyc_wdata,
    .bus_addr, .bus_bhe_n, .bus_rd_n, .bus_wr_n, .bus_cs_n, .bus_ale,
    .bus_dout, .bus_doe
  );
endmodule

// File: rtl/wsc_chk.sv
module wsc_chk #(
  parameter int N_AREA = 4,
  parameter int AW = 20
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  req_ready,
  input logic                  rsp_valid,
  input logic                  bus_rd_n,
  input logic                  bus_wr_n,
  input logic [N_AREA-1:0]     bus_cs_n,
  input logic                  bus_ale,
  input logic                  bus_doe,
  input logic [AW-1:0]         bus_addr,
  input logic                  bus_bhe_n,
  input logic                  cyc_active,
  input logic                  cyc_int,
  input logic                  xw_we,
  input logic [2*N_AREA-1:0]   xw_data,
  input logic                  we_we,
  input logic [N_AREA-1:0]     we_data,
  input logic [2*N_AREA-1:0]   cfg_xreg,
  input logic [N_AREA-1:0]     cfg_wen,
  input logic                  cfg_order_err
);
  AST_CS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n)) else $error("chip selects overlap"); // R12

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n)) else $error("read and write strobes together"); // R12

  AST_ALE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ale |-> $past(req_ready)) else $error("ALE beyond first clock"); // R12

  AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (bus_rd_n && bus_wr_n && (&bus_cs_n) && !bus_ale))
    else $error("pins not idle"); // R7

  AST_INT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && cyc_int) |-> (bus_rd_n && bus_wr_n && (&bus_cs_n) && !bus_ale && !bus_doe))
    else $error("pins active on internal access"); // R6

  AST_INT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_active && cyc_int) |-> ($stable(bus_addr) && $stable(bus_bhe_n)))
    else $error("address moved on internal access"); // R6

  AST_RSP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!req_ready) && req_ready)) else $error("stray response"); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_order_err |=> cfg_order_err) else $error("order flag cleared"); // R10

  for (genvar g = 0; g < N_AREA; g++) begin : g_ord
    AST_XREG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (xw_we && cfg_wen[g] && (xw_data[2*g +: 2] != cfg_xreg[2*g +: 2]))
      |=> (cfg_order_err && (cfg_xreg[2*g +: 2] == $past(cfg_xreg[2*g +: 2]))))
      else $error("wait count changed while no-wait"); // R8

    AST_WEN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (we_we && we_data[g] && !cfg_wen[g] && (cfg_xreg[2*g +: 2] != 2'b00))
      |=> (cfg_order_err && !cfg_wen[g]))
      else $error("no-wait set with nonzero count"); // R9
  end
endmodule

bind ebus_wait_ctrl wsc_chk #(.N_AREA(N_AREA), .AW(AW)) u_chk (
  .clk, .rst_n, .req_ready, .rsp_valid, .bus_rd_n, .bus_wr_n, .bus_cs_n,
  .bus_ale, .bus_doe, .bus_addr, .bus_bhe_n, .cyc_active, .cyc_int,
  .xw_we, .xw_data, .we_we, .we_data, .cfg_xreg, .cfg_wen, .cfg_order_err
);

// File: tb/ebus_wait_ctrl_tb.sv
module ebus_wait_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        xw_we = 1'b0;
  logic [7:0]  xw_data = '0;
  logic        we_we = 1'b0;
  logic [3:0]  we_data = '0;
  logic        sfr_3clk = 1'b0;
  logic [7:0]  cfg_xreg;
  logic [3:0]  cfg_wen;
  logic        cfg_order_err, cfg_illegal;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_area = '0;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_bhe_n = 1'b1;
  logic [15:0] req_wdata = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [19:0] bus_addr;
  logic        bus_bhe_n, bus_rd_n, bus_wr_n, bus_ale, bus_doe;
  logic [3:0]  bus_cs_n;
  logic [15:0] bus_dout;
  logic [15:0] bus_din = '0;
  logic        bus_rdy = 1'b1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ebus_wait_ctrl u_dut (.*);

  typedef struct {
    int          busy;
    int          rd_cyc;
    int          wr_cyc;
    int          ale_cyc;
    logic [15:0] rdata;
    string       req;
  } exp_t;

  exp_t q[$];
  logic [3:0] exp_csn = 4'hF;
  int rdy_hold = 0;
  int busy_n = 0, rd_n = 0, wr_n = 0, ale_n = 0, cs_bad = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Monitor: counts strobe activity per cycle and compares on response.
  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) begin
        busy_n++;
        if (!bus_rd_n) rd_n++;
        if (!bus_wr_n) wr_n++;
        if (bus_ale) ale_n++;
        if (bus_cs_n != exp_csn) cs_bad++;
        if (busy_n >= rdy_hold) bus_rdy = 1'b1;
      end
      if (rsp_valid) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected response", 1, 0);
        end else begin
          exp_t e;
          e = q.pop_front();
          chk(busy_n == e.busy, e.req, "busy clocks", busy_n, e.busy);
          chk(rd_n == e.rd_cyc && wr_n == e.wr_cyc, "R12", "strobe clocks",
              rd_n * 100 + wr_n, e.rd_cyc * 100 + e.wr_cyc);
          chk(ale_n == e.ale_cyc, "R12", "ALE clocks", ale_n, e.ale_cyc);
          chk(cs_bad == 0, "R12", "chip-select pattern", cs_bad, 0);
          chk(rsp_rdata == e.rdata, "R11", "read data", rsp_rdata, e.rdata);
        end
        busy_n = 0; rd_n = 0; wr_n = 0; ale_n = 0; cs_bad = 0;
      end
    end
  end

  // Driver: queues the expectation, then offers one request.
  task automatic access(input int area, input bit wr, input logic [19:0] addr,
                        input logic bhe, input logic [15:0] wd,
                        input int exp_busy, input int hold, input string req);
    exp_t e;
    bit ext = (area < 5);
    @(negedge clk);
    bus_din   = wd ^ 16'hA5A5;
    rdy_hold  = hold;
    bus_rdy   = (hold == 0);
    exp_csn   = (area < 4) ? ~(4'b0001 << area) : 4'hF;
    e.busy    = exp_busy;
    e.rd_cyc  = (ext && !wr) ? exp_busy : 0;
    e.wr_cyc  = (ext && wr) ? exp_busy : 0;
    e.ale_cyc = ext ? 1 : 0;
    e.rdata   = (ext && !wr) ? (wd ^ 16'hA5A5) : 16'h0000;
    e.req     = req;
    q.push_back(e);
    req_valid = 1'b1; req_area = 3'(area); req_write = wr;
    req_addr  = addr; req_bhe_n = bhe; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic wr_x(input logic [7:0] d);
    @(negedge clk); xw_we = 1'b1; xw_data = d;
    @(negedge clk); xw_we = 1'b0;
  endtask

  task automatic wr_e(input logic [3:0] d);
    @(negedge clk); we_we = 1'b1; we_data = d;
    @(negedge clk); we_we = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: reset state
    chk(cfg_xreg == 8'h00 && cfg_wen == 4'h0 && !cfg_order_err, "R7", "config reset",
        {cfg_xreg, cfg_wen, cfg_order_err}, 0);
    chk(req_ready && bus_rd_n && bus_wr_n && bus_cs_n == 4'hF && !bus_ale, "R7", "idle pins",
        {req_ready, bus_rd_n, bus_wr_n, bus_cs_n, bus_ale}, 8'b1111_1110);

    // R1: code 00 everywhere gives 2 clocks
    access(0, 0, 20'h00100, 1'b0, 16'h1111, 2, 0, "R1");
    access(1, 1, 20'h00200, 1'b1, 16'h2222, 2, 0, "R1");
    // R1: area0=01, area1=00, area2=01, area3=10
    wr_x(8'h91);
    chk(cfg_xreg == 8'h91 && !cfg_order_err, "R1", "wait-count write", cfg_xreg, 8'h91);
    access(0, 0, 20'h00300, 1'b0, 16'h3333, 3, 0, "R1");
    access(3, 1, 20'h00400, 1'b0, 16'h4444, 4, 0, "R1");
    access(2, 0, 20'h00500, 1'b0, 16'h5555, 3, 0, "R1");

    // R4: ready low stretches a waited region
    access(3, 0, 20'h00600, 1'b0, 16'h6666, 7, 7, "R4");
    access(0, 0, 20'h00700, 1'b0, 16'h7777, 3, 2, "R4");

    // R3: code 11 acts as three waits and raises the flag
    wr_x(8'hD1);
    chk(cfg_illegal, "R3", "illegal flag set", cfg_illegal, 1);
    access(3, 0, 20'h00800, 1'b0, 16'h8888, 4, 0, "R3");

    // R9 accepted case, then R8 refusal of area1 field while it runs without waits
    wr_e(4'b0010);
    chk(cfg_wen == 4'b0010 && !cfg_order_err, "R9", "legal no-wait set", cfg_wen, 4'b0010);
    wr_x(8'hD6);
    chk(cfg_xreg == 8'hD2, "R8", "blocked field kept", cfg_xreg, 8'hD2);
    chk(cfg_order_err, "R8", "order flag set", cfg_order_err, 1);

    // R2: no-wait region is one clock and ignores ready
    access(1, 0, 20'h00900, 1'b0, 16'h9999, 1, 5, "R2");

    // R9: setting no-wait with nonzero count is refused
    wr_e(4'b0011);
    chk(cfg_wen == 4'b0010, "R9", "blocked no-wait bit", cfg_wen, 4'b0010);

    // R5: SFR lengths, no chip select, ready ignored
    sfr_3clk = 1'b0;
    access(4, 0, 20'h003A0, 1'b0, 16'hAAAA, 2, 0, "R5");
    sfr_3clk = 1'b1;
    access(4, 1, 20'h003A2, 1'b0, 16'hBBBB, 3, 6, "R5");

    // R6: internal accesses keep the last external address
    access(0, 1, 20'h12345, 1'b0, 16'hCCCC, 4, 0, "R6");
    access(5, 0, 20'hFFFFF, 1'b1, 16'hDDDD, 1, 0, "R6");
    chk(bus_addr == 20'h12345 && !bus_bhe_n, "R6", "address held",
        {bus_addr, bus_bhe_n}, {20'h12345, 1'b0});
    access(7, 1, 20'hEEEEE, 1'b1, 16'hEEEE, 1, 0, "R6");
    chk(bus_addr == 20'h12345 && !bus_doe, "R6", "held after internal write",
        bus_addr, 20'h12345);

    // R13: length latched at acceptance (area2 code 01 -> 3 clocks)
    fork
      access(2, 0, 20'h01000, 1'b0, 16'h0F0F, 3, 0, "R13");
      begin
        @(negedge clk); @(negedge clk);
        wr_x(8'hE2);
      end
    join
    chk(cfg_xreg == 8'hE2, "R13", "mid-cycle write taken", cfg_xreg, 8'hE2);
    access(2, 0, 20'h01002, 1'b0, 16'hF0F0, 4, 0, "R13");

    // R3: flag clears once no field holds 11
    wr_x(8'h22);
    chk(!cfg_illegal && cfg_xreg == 8'h22, "R3", "illegal flag clear", cfg_illegal, 0);
    // R10: order flag is still set
    chk(cfg_order_err, "R10", "sticky order flag", cfg_order_err, 1);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule